// File: doc/BRIEF.md
# Indexed Block-Transfer I2C Configuration Target

This block is an I2C target that holds a bank of sixteen 8-bit configuration registers for the rest of the chip. A controller writes by addressing the target, sending a start location and then a byte count, followed by data bytes. The target stores exactly that many bytes at consecutive locations, and the location wraps around the top of the bank. A controller reads by first setting the location in a short write phase. It then issues a repeated START and the read address. The target answers with a length byte taken from register 8, then streams register contents from the chosen location until the controller declines a byte.

SCL and SDA enter through two-flop synchronizers clocked by the system clock, which must run at least eight times faster than SCL. START, STOP and both SCL edges are detected on the synchronized lines. The target samples SDA when SCL rises and changes its own open-drain drive only after SCL has fallen. The whole bank is presented on a flat parallel output, so downstream logic sees each byte as soon as it is committed.

Top module: `blkreg_i2c_target`

## Requirements
- R1: After reset, every register reads 0x00 on the parallel port and the target does not pull SDA low.
- R2: The target acknowledges only the 8-bit address bytes 0xD2 (write, bit 0 = 0) and 0xD3 (read, bit 0 = 1). After any other address byte it leaves SDA released until the next START.
- R3: In a write, the byte after 0xD2 selects the start location N from its low 4 bits, the next byte gives the count X, and the next X data bytes go to locations N, N+1, … N+X-1. The target acknowledges every byte.
- R4: Auto-increment of the location wraps from 15 to 0, for writes and for reads.
- R5: A data byte appears on the parallel port when the target starts driving its acknowledge, which happens after the SCL falling edge that ends the eighth bit and before the ninth SCL rise.
- R6: Data bytes sent after X bytes have been stored are acknowledged but are not stored anywhere.
- R7: After 0xD2, an index N, a repeated START and 0xD3, the target first sends the value of register 8 and then registers N, N+1, … in turn, MSB first.
- R8: The target keeps sending while the controller acknowledges. After a NACK it stops and releases SDA.
- R9: A STOP returns the target to idle at any point. A STOP or START that arrives inside a data byte leaves every register unchanged.
- R10: A START, including a repeated START, restarts address reception, so a valid transaction can follow an aborted one at once.
- R11: The target changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 8x the SCL rate |
| rst_i | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level (wired-AND bus value) |
| sda_oe_o | output | 1 | 1 = pull SDA low, 0 = release |
| regs_o | output | 128 | Register bank, location k at bits [8k+7:8k] |

## Verification
A write sweep starts once at each of the sixteen locations with counts from one to four. It checks every location on the parallel port after each byte and after each STOP, which shows whether bytes land at the right location and only there. Separate write patterns cover a run that wraps past location 15, a run that sends more data bytes than its count, addresses other than the two valid ones, and STOP or repeated START in the middle of a byte. These patterns separate wrap, over-count and abort handling from plain storage. A read sweep starts at every location with varying lengths and ends with a NACK. It shows that the count from register 8 comes first and that the data follows in sequence with wrap. A bus monitor confirms that the target's drive never changes while SCL is high.

// File: rtl/blkreg_pkg.sv
package blkreg_pkg;
  typedef enum logic [2:0] {
    PH_IDLE, PH_RX, PH_ACK_WAIT, PH_ACK_DRV, PH_TX, PH_MACK_WAIT, PH_MACK
  } phase_e;

  typedef enum logic [1:0] {K_ADDR, K_IDX, K_CNT, K_DATA} kind_e;
endpackage

// File: rtl/blk_sync2.sv
module blk_sync2 #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk_i) begin
    if (rst_i) pipe <= '1;
    else       pipe <= {pipe[STAGES-2:0], d_i};
  end

  assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/blk_bus_cond.sv
module blk_bus_cond (
  input  logic clk_i,
  input  logic rst_i,
  input  logic scl_s_i,
  input  logic sda_s_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_p, sda_p;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_s_i;
      sda_p <= sda_s_i;
    end
  end

  assign scl_rise_o = scl_s_i & ~scl_p;
  assign scl_fall_o = ~scl_s_i & scl_p;
  assign start_o    = scl_s_i & scl_p & sda_p & ~sda_s_i;
  assign stop_o     = scl_s_i & scl_p & ~sda_p & sda_s_i;
endmodule

// File: rtl/blk_regfile.sv
module blk_regfile #(
  parameter int NREG = 16,
  parameter int DW   = 8,
  localparam int IW  = $clog2(NREG)
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic               we_i,
  input  logic [IW-1:0]      waddr_i,
  input  logic [DW-1:0]      wdata_i,
  output logic [NREG*DW-1:0] q_o
);
  logic [DW-1:0] mem [NREG];

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
    end else if (we_i) begin
      mem[waddr_i] <= wdata_i;
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_flat
    assign q_o[g*DW +: DW] = mem[g];
  end
endmodule

// File: rtl/blkreg_i2c_target.sv
module blkreg_i2c_target
  import blkreg_pkg::*;
#(
  parameter int         NREG     = 16,
  parameter int         DW       = 8,
  parameter int         CNT_REG  = 8,
  parameter logic [6:0] DEV_ADDR = 7'h69,
  localparam int        IW       = $clog2(NREG)
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe_o,
  output logic [NREG*DW-1:0] regs_o
);
  logic scl_s, sda_s;
  logic scl_rise, scl_fall, start_evt, stop_evt;

  blk_sync2 #(.STAGES(2)) u_scl_sync (.clk_i(clk_i), .rst_i(rst_i), .d_i(scl_i), .q_o(scl_s));
  blk_sync2 #(.STAGES(2)) u_sda_sync (.clk_i(clk_i), .rst_i(rst_i), .d_i(sda_i), .q_o(sda_s));

  blk_bus_cond u_cond (
    .clk_i(clk_i), .rst_i(rst_i), .scl_s_i(scl_s), .sda_s_i(sda_s),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_evt), .stop_o(stop_evt)
  );

  phase_e        phase;
  kind_e         kind;
  logic          rd_mode;
  logic [2:0]    bitcnt;
  logic [DW-1:0] rx_sh, tx_sh, rem;
  logic [IW-1:0] idx, waddr_q;
  logic [DW-1:0] wdata_q;
  logic          we_q;
  logic [DW-1:0] rx_byte, cnt_val, cur_val;

  assign rx_byte = {rx_sh[DW-2:0], sda_s};
  assign cnt_val = regs_o[CNT_REG*DW +: DW];
  assign cur_val = regs_o[idx*DW +: DW];

  function automatic logic [IW-1:0] nxt(input logic [IW-1:0] i);
    return (i == IW'(NREG-1)) ? '0 : i + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      phase    <= PH_IDLE;
      kind     <= K_ADDR;
      rd_mode  <= 1'b0;
      bitcnt   <= '0;
      rx_sh    <= '0;
      tx_sh    <= '0;
      rem      <= '0;
      idx      <= '0;
      waddr_q  <= '0;
      wdata_q  <= '0;
      we_q     <= 1'b0;
      sda_oe_o <= 1'b0;
    end else begin
      we_q <= 1'b0;
      if (start_evt) begin
        phase    <= PH_RX;
        kind     <= K_ADDR;
        bitcnt   <= '0;
        sda_oe_o <= 1'b0;
      end else if (stop_evt) begin
        phase    <= PH_IDLE;
        sda_oe_o <= 1'b0;
      end else begin
        case (phase)
          PH_RX: if (scl_rise) begin
            rx_sh  <= rx_byte;
            bitcnt <= bitcnt + 3'd1;
            if (bitcnt == 3'd7) begin
              if (kind == K_ADDR) begin
                if (rx_byte[7:1] == DEV_ADDR) begin
                  rd_mode <= rx_byte[0];
                  phase   <= PH_ACK_WAIT;
                end else begin
                  phase <= PH_IDLE;
                end
              end else begin
                phase <= PH_ACK_WAIT;
              end
            end
          end
          PH_ACK_WAIT: if (scl_fall) begin
            sda_oe_o <= 1'b1;
            phase    <= PH_ACK_DRV;
            case (kind)
              K_IDX:  idx <= rx_sh[IW-1:0];
              K_CNT:  rem <= rx_sh;
              K_DATA: if (rem != '0) begin
                we_q    <= 1'b1;
                waddr_q <= idx;
                wdata_q <= rx_sh;
                idx     <= nxt(idx);
                rem     <= rem - 1'b1;
              end
              default: ;
            endcase
          end
          PH_ACK_DRV: if (scl_fall) begin
            bitcnt <= '0;
            if (kind == K_ADDR && rd_mode) begin
              tx_sh    <= cnt_val;
              sda_oe_o <= ~cnt_val[DW-1];
              kind     <= K_DATA;
              phase    <= PH_TX;
            end else begin
              sda_oe_o <= 1'b0;
              phase    <= PH_RX;
              case (kind)
                K_ADDR:  kind <= K_IDX;
                K_IDX:   kind <= K_CNT;
                default: kind <= K_DATA;
              endcase
            end
          end
          PH_TX: begin
            if (scl_fall) sda_oe_o <= ~tx_sh[DW-1];
            if (scl_rise) begin
              tx_sh  <= {tx_sh[DW-2:0], 1'b0};
              bitcnt <= bitcnt + 3'd1;
              if (bitcnt == 3'd7) phase <= PH_MACK_WAIT;
            end
          end
          PH_MACK_WAIT: if (scl_fall) begin
            sda_oe_o <= 1'b0;
            phase    <= PH_MACK;
          end
          PH_MACK: if (scl_rise) begin
            if (!sda_s) begin
              tx_sh  <= cur_val;
              idx    <= nxt(idx);
              bitcnt <= '0;
              phase  <= PH_TX;
            end else begin
              phase <= PH_IDLE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  blk_regfile #(.NREG(NREG), .DW(DW)) u_bank (
    .clk_i(clk_i), .rst_i(rst_i), .we_i(we_q),
    .waddr_i(waddr_q), .wdata_i(wdata_q), .q_o(regs_o)
  );
endmodule

// File: rtl/blkreg_i2c_chk.sv
module blkreg_i2c_chk
  import blkreg_pkg::*;
(
  input logic   clk,
  input logic   rst,
  input logic   scl_s,
  input logic   sda_oe,
  input logic   we,
  input logic   start_evt,
  input logic   stop_evt,
  input phase_e phase
);
  // R11: drive changes only while synchronized SCL is low
  a_r11_drive_scl_low: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> !scl_s);

  // R5: a bank write coincides with the acknowledge being driven
  a_r5_write_with_ack: assert property (@(posedge clk) disable iff (rst)
    we |-> sda_oe);

  // R9: STOP leads to idle
  a_r9_stop_idles: assert property (@(posedge clk) disable iff (rst)
    stop_evt |=> (phase == PH_IDLE));

  // R10: START restarts reception with SDA released
  a_r10_start_restarts: assert property (@(posedge clk) disable iff (rst)
    start_evt |=> (phase == PH_RX && !sda_oe));

  // R2: an idle target never pulls SDA
  a_r2_idle_released: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_IDLE) |-> !sda_oe);
endmodule

bind blkreg_i2c_target blkreg_i2c_chk chk_i (
  .clk(clk_i), .rst(rst_i), .scl_s(scl_s), .sda_oe(sda_oe_o),
  .we(we_q), .start_evt(start_evt), .stop_evt(stop_evt), .phase(phase)
);

// File: tb/blkreg_i2c_target_tb_top.sv
`timescale 1ns/1ps
module blkreg_i2c_target_tb_top;
  localparam int NREG = 16;
  localparam int Q    = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_oe;
  logic sda_bus;
  logic [NREG*8-1:0] regs;

  always #10 clk = ~clk;

  assign sda_bus = m_sda & ~sda_oe;

  blkreg_i2c_target dut_i (
    .clk_i(clk), .rst_i(rst), .scl_i(m_scl), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .regs_o(regs)
  );

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0] exp_reg [NREG];
  logic oe_at_rise = 1'b0;
  int r11_viol = 0;

  always @(posedge m_scl) oe_at_rise = sda_oe;
  always @(negedge m_scl) if (sda_oe !== oe_at_rise) r11_viol++;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
    end
  endtask

  task automatic qw();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bstart();
    m_sda = 1'b1; qw(); m_scl = 1'b1; qw(); m_sda = 1'b0; qw(); m_scl = 1'b0; qw();
  endtask

  task automatic bstop();
    m_sda = 1'b0; qw(); m_scl = 1'b1; qw(); m_sda = 1'b1; qw();
  endtask

  task automatic send_bits(input logic [7:0] b, input int nb);
    for (int i = 7; i > 7 - nb; i--) begin
      m_sda = b[i]; qw(); m_scl = 1'b1; qw(); qw(); m_scl = 1'b0; qw();
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    m_sda = 1'b1; qw(); m_scl = 1'b1; qw(); ack = ~sda_bus; qw(); m_scl = 1'b0; qw();
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    m_sda = 1'b1;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      qw(); m_scl = 1'b1; qw(); b = {b[6:0], sda_bus}; qw(); m_scl = 1'b0;
    end
    m_sda = give_ack ? 1'b0 : 1'b1; qw(); m_scl = 1'b1; qw(); qw(); m_scl = 1'b0; qw();
    m_sda = 1'b1;
  endtask

  task automatic cmp_all(input string tag);
    for (int k = 0; k < NREG; k++) chk(tag, regs[k*8 +: 8], exp_reg[k]);
  endtask

  // R3 R4 R5 R6: block write of nsent bytes with declared count cnt
  task automatic blk_write(input int n, input int cnt, input int nsent, input int seed);
    logic a;
    logic [7:0] d;
    int loc;
    bstart();
    send_byte(8'hD2, a);        chk("R2 write address ack", a, 1);
    send_byte(8'(n), a);        chk("R3 index ack", a, 1);
    send_byte(8'(cnt), a);      chk("R3 count ack", a, 1);
    for (int k = 0; k < nsent; k++) begin
      d = 8'((seed * 37 + k * 11 + 5) & 255);
      loc = (n + k) % NREG;
      send_byte(d, a);
      chk(k < cnt ? "R3 data ack" : "R6 extra byte ack", a, 1);
      if (k < cnt) begin
        exp_reg[loc] = d;
        chk("R5 byte visible at ack", regs[loc*8 +: 8], d);
      end
    end
    bstop();
    cmp_all(nsent > cnt ? "R6 bank after over-count" : "R3 bank after write");
  endtask

  // R7 R8 R4: indexed read of nb data bytes
  task automatic blk_read(input int n, input int nb);
    logic a;
    logic [7:0] d;
    bstart();
    send_byte(8'hD2, a);   chk("R7 read setup address ack", a, 1);
    send_byte(8'(n), a);   chk("R7 read index ack", a, 1);
    bstart();
    send_byte(8'hD3, a);   chk("R2 read address ack", a, 1);
    recv_byte(1'b1, d);    chk("R7 count byte from reg 8", d, exp_reg[8]);
    for (int k = 0; k < nb; k++) begin
      recv_byte(k < nb - 1, d);
      chk("R7 R4 read data", d, exp_reg[(n + k) % NREG]);
    end
    chk("R8 released after NACK", sda_oe, 0);
    bstop();
  endtask

  initial begin : main
    logic a;
    for (int k = 0; k < NREG; k++) exp_reg[k] = 8'h00;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 sda released", sda_oe, 0);
    cmp_all("R1 reset bank");

    // R3 R5 sweep over start locations and counts
    for (int s = 0; s < NREG; s++) blk_write(s, (s % 4) + 1, (s % 4) + 1, s);

    // R4 wrap on write
    blk_write(14, 4, 4, 40);
    // R6 bytes beyond count
    blk_write(3, 2, 4, 50);

    // R7 R8 read sweep, count register programmed first
    blk_write(8, 1, 1, 60);
    for (int s = 0; s < NREG; s++) blk_read(s, (s % 3) + 1);
    blk_read(14, 4);

    // R2 foreign addresses
    bstart(); send_byte(8'hA4, a); chk("R2 foreign address nack", a, 0);
    send_byte(8'h01, a); chk("R2 stays released", a, 0); bstop();
    bstart(); send_byte(8'hD0, a); chk("R2 near address nack", a, 0);
    send_byte(8'h05, a); bstop();
    cmp_all("R2 bank untouched");

    // R9 STOP inside a data byte
    bstart(); send_byte(8'hD2, a); send_byte(8'h02, a); send_byte(8'h01, a);
    send_bits(8'hFF, 4); bstop();
    cmp_all("R9 mid-byte stop");

    // R10 repeated START inside a data byte, then a valid write
    bstart(); send_byte(8'hD2, a); send_byte(8'h05, a); send_byte(8'h01, a);
    send_bits(8'h3C, 5);
    bstart(); send_byte(8'hD2, a); chk("R10 address after restart", a, 1);
    send_byte(8'h0B, a); send_byte(8'h01, a); send_byte(8'h9A, a);
    chk("R10 data ack after restart", a, 1);
    exp_reg[11] = 8'h9A;
    bstop();
    cmp_all("R10 R9 bank after restart");

    chk("R11 drive steady while SCL high", r11_viol, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule